// File: doc/BRIEF.md
# Status Channel Frame Generator

This block produces the flow-control status stream that a packet receiver sends back to its transmitter. Every accepted output word is a 2-bit status value. A frame opens with the framing word `2'b11`. When bank signalling is turned on, a select word follows that names the calendar bank in use. The frame then walks the calendar entries of the active bank from index 0 to length-1, and repeats that pass a programmed number of times before the next framing word. Each calendar entry holds a port number. The block presents that number on `stat_port`, and the port status source outside the block answers on `stat_val` in the same cycle. That answer becomes the output word.

There are two calendar banks, each with its own length and repetition count. The bank request, the lengths, the repetition counts, the select-word enable and the hold request are sampled only at a frame boundary, so the stream can switch banks without a gap or a torn frame. A frame boundary is the acceptance of the last word of a frame. While hold is latched, or while the latched bank has a length or repetition count of zero, every frame is a single framing word and `disabled` is high.

The output is a valid/ready stream. `out_valid` goes high one cycle after reset is released and then stays high. A word is consumed in a cycle where `out_ready` is high. While `out_ready` is low the sequence does not advance, and `out_data` and `stat_port` hold their values, provided `stat_val` follows `stat_port`. Calendar contents are loaded through a plain write port.

Top module: `status_frame_gen`

## Requirements
- R1: During reset `out_valid` is 0, `out_data` is `2'b11`, `disabled` is 1 and `act_bank` is 0. From the first clock after reset is released, `out_valid` is 1.
- R2: A hold request raised in the middle of a frame lets that frame finish. From the next frame boundary on, only framing words `2'b11` are sent for as long as hold stays high.
- R3: After hold is cleared, the next frame boundary restores normal frames.
- R4: When the select-word enable was latched high, the word after the framing word is `2'b01` if bank 0 is active and `2'b10` if bank 1 is active. When it was latched low, no select word is sent.
- R5: A bank request is adopted only at a frame boundary. `act_bank` reports the bank that the current frame uses.
- R6: A normal frame is the framing word, then the optional select word, then entries 0 to length-1 repeated as many times as the repetition count, then the next framing word.
- R7: For each entry word, `stat_port` equals the port number stored at that index of the active bank, and `out_data` equals `stat_val`.
- R8: `disabled` is 1 while hold is latched or while the latched length or repetition count is zero. While `disabled` is 1, every word is `2'b11`.
- R9: Length, repetition count, bank and select enable changed in the middle of a frame do not affect that frame. They take effect from the next frame.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `stat_port` and `act_bank` hold their values and the sequence does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold | input | 1 | Request to send only framing words |
| hitless_en | input | 1 | Enable the bank select word in each frame |
| bank_req | input | 1 | Requested calendar bank |
| cal_len0 | input | LEN_W | Entry count of bank 0 |
| cal_len1 | input | LEN_W | Entry count of bank 1 |
| cal_mul0 | input | MUL_W | Repetition count of bank 0 |
| cal_mul1 | input | MUL_W | Repetition count of bank 1 |
| cal_wr_en | input | 1 | Calendar write strobe |
| cal_wr_bank | input | 1 | Bank written |
| cal_wr_addr | input | LEN_W | Entry index written |
| cal_wr_port | input | PORT_W | Port number written |
| stat_port | output | PORT_W | Port whose status is requested |
| stat_val | input | 2 | Status of `stat_port`, same cycle |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 2 | Status stream word |
| act_bank | output | 1 | Bank in use by the current frame |
| disabled | output | 1 | Framing-only mode active |

## Verification
The assertions check, on every cycle, the rules that need no frame history: valid stays high after reset, nothing moves during a stall, a bank change appears only on a framing word, a disabled frame carries only framing words, and the select word carries the right code. The bench scenarios are the only way to show that frame order, lengths and repetition counts are correct. They also show that entries map to the right stored port numbers, that a mid-frame hold or configuration change waits for the boundary, and that normal frames return after hold is cleared.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  typedef enum logic [1:0] {
    ST_FRAME = 2'd0,
    ST_SEL   = 2'd1,
    ST_ENTRY = 2'd2
  } seq_state_t;

  localparam logic [1:0] WORD_FRAMING = 2'b11;

  function automatic logic [1:0] sel_code(input logic bank);
    return bank ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/sfg_cal_ram.sv
module sfg_cal_ram #(
  parameter int LEN_W  = 10,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [LEN_W-1:0]  wr_addr,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              rd_bank,
  input  logic [LEN_W-1:0]  rd_addr,
  output logic [PORT_W-1:0] rd_data
);
  localparam int DEPTH     = 1 << LEN_W;
  localparam int NUM_BANKS = 2;

  logic [PORT_W-1:0] bank_rd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [PORT_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) mem[wr_addr] <= wr_data;
    end
    assign bank_rd[b] = mem[rd_addr];
  end

  assign rd_data = bank_rd[rd_bank];
endmodule

// File: rtl/sfg_seq.sv
module sfg_seq
  import sfg_pkg::*;
#(
  parameter int LEN_W = 10,
  parameter int MUL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             hold,
  input  logic             hitless_en,
  input  logic             bank_req,
  input  logic [LEN_W-1:0] len0,
  input  logic [LEN_W-1:0] len1,
  input  logic [MUL_W-1:0] mul0,
  input  logic [MUL_W-1:0] mul1,
  output seq_state_t       state,
  output logic [LEN_W-1:0] idx,
  output logic             bank_act,
  output logic             sel_en_act,
  output logic             disabled
);
  logic             hold_act;
  logic [LEN_W-1:0] len_act;
  logic [MUL_W-1:0] mul_act;
  logic [MUL_W-1:0] rep;
  logic             last_idx, last_rep, boundary;

  always_comb begin
    disabled = hold_act || (len_act == '0) || (mul_act == '0);
    last_idx = (idx == len_act - LEN_W'(1));
    last_rep = (rep == mul_act - MUL_W'(1));
    boundary = adv && (((state == ST_FRAME) && disabled) ||
                       ((state == ST_ENTRY) && last_idx && last_rep));
  end

  // Frame parameters are captured only at a boundary (R5, R9).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_act   <= 1'b1;
      bank_act   <= 1'b0;
      sel_en_act <= 1'b0;
      len_act    <= '0;
      mul_act    <= '0;
    end else if (boundary) begin
      hold_act   <= hold;
      bank_act   <= bank_req;
      sel_en_act <= hitless_en;
      len_act    <= bank_req ? len1 : len0;
      mul_act    <= bank_req ? mul1 : mul0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FRAME;
      idx   <= '0;
      rep   <= '0;
    end else if (adv) begin
      unique case (state)
        ST_FRAME: begin
          idx <= '0;
          rep <= '0;
          if (disabled)        state <= ST_FRAME;
          else if (sel_en_act) state <= ST_SEL;
          else                 state <= ST_ENTRY;
        end
        ST_SEL: begin
          state <= ST_ENTRY;
        end
        ST_ENTRY: begin
          if (last_idx) begin
            idx <= '0;
            if (last_rep) begin
              rep   <= '0;
              state <= ST_FRAME;
            end else begin
              rep <= rep + MUL_W'(1);
            end
          end else begin
            idx <= idx + LEN_W'(1);
          end
        end
        default: state <= ST_FRAME;
      endcase
    end
  end
endmodule

// File: rtl/sfg_word_mux.sv
module sfg_word_mux
  import sfg_pkg::*;
(
  input  seq_state_t state,
  input  logic       bank,
  input  logic [1:0] stat_val,
  output logic [1:0] word
);
  always_comb begin
    unique case (state)
      ST_FRAME: word = WORD_FRAMING;
      ST_SEL:   word = sel_code(bank);
      ST_ENTRY: word = stat_val;
      default:  word = WORD_FRAMING;
    endcase
  end
endmodule

// File: rtl/status_frame_gen.sv
module status_frame_gen
  import sfg_pkg::*;
#(
  parameter int LEN_W  = 10,
  parameter int MUL_W  = 8,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              hitless_en,
  input  logic              bank_req,
  input  logic [LEN_W-1:0]  cal_len0,
  input  logic [LEN_W-1:0]  cal_len1,
  input  logic [MUL_W-1:0]  cal_mul0,
  input  logic [MUL_W-1:0]  cal_mul1,
  input  logic              cal_wr_en,
  input  logic              cal_wr_bank,
  input  logic [LEN_W-1:0]  cal_wr_addr,
  input  logic [PORT_W-1:0] cal_wr_port,
  output logic [PORT_W-1:0] stat_port,
  input  logic [1:0]        stat_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_data,
  output logic              act_bank,
  output logic              disabled
);
  seq_state_t       seq_state;
  logic [LEN_W-1:0] seq_idx;
  logic             valid_q;
  logic             adv;
  logic             sel_en_act;
  logic             at_framing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= 1'b1;
  end

  assign out_valid  = valid_q;
  assign adv        = valid_q && out_ready;
  assign at_framing = (seq_state == ST_FRAME);

  sfg_seq #(.LEN_W(LEN_W), .MUL_W(MUL_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .hold       (hold),
    .hitless_en (hitless_en),
    .bank_req   (bank_req),
    .len0       (cal_len0),
    .len1       (cal_len1),
    .mul0       (cal_mul0),
    .mul1       (cal_mul1),
    .state      (seq_state),
    .idx        (seq_idx),
    .bank_act   (act_bank),
    .sel_en_act (sel_en_act),
    .disabled   (disabled)
  );

  sfg_cal_ram #(.LEN_W(LEN_W), .PORT_W(PORT_W)) u_ram (
    .clk     (clk),
    .wr_en   (cal_wr_en),
    .wr_bank (cal_wr_bank),
    .wr_addr (cal_wr_addr),
    .wr_data (cal_wr_port),
    .rd_bank (act_bank),
    .rd_addr (seq_idx),
    .rd_data (stat_port)
  );

  sfg_word_mux u_mux (
    .state    (seq_state),
    .bank     (act_bank),
    .stat_val (stat_val),
    .word     (out_data)
  );
endmodule

// File: rtl/status_frame_gen_chk.sv
module status_frame_gen_chk #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_data,
  input logic [PORT_W-1:0] stat_port,
  input logic              act_bank,
  input logic              disabled,
  input logic              at_framing,
  input logic              sel_en_act
);
  p_valid_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid);

  p_stall_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(stat_port) && $stable(act_bank) && $stable(disabled)));

  p_bank_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_bank) |-> (out_data == 2'b11));

  p_disabled_framing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    disabled |-> (out_data == 2'b11));

  p_select_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && at_framing && !disabled && sel_en_act)
      |=> (out_data == (act_bank ? 2'b10 : 2'b01)));
endmodule

bind status_frame_gen status_frame_gen_chk #(.PORT_W(PORT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .stat_port  (stat_port),
  .act_bank   (act_bank),
  .disabled   (disabled),
  .at_framing (at_framing),
  .sel_en_act (sel_en_act)
);

// File: tb/test_status_frame_gen.sv
module test_status_frame_gen;
  localparam int LEN_W  = 10;
  localparam int MUL_W  = 8;
  localparam int PORT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold = 1'b1, hitless_en = 1'b0, bank_req = 1'b0;
  logic [LEN_W-1:0] cal_len0 = '0, cal_len1 = '0;
  logic [MUL_W-1:0] cal_mul0 = '0, cal_mul1 = '0;
  logic cal_wr_en = 1'b0, cal_wr_bank = 1'b0;
  logic [LEN_W-1:0] cal_wr_addr = '0;
  logic [PORT_W-1:0] cal_wr_port = '0;
  logic [PORT_W-1:0] stat_port;
  logic [1:0] stat_val;
  logic out_valid, out_ready = 1'b1, act_bank, disabled;
  logic [1:0] out_data;

  always #2.5 clk = ~clk;

  // Status source: never returns 2'b11, so entries cannot look like framing.
  assign stat_val = {1'b0, stat_port[0]};

  status_frame_gen #(.LEN_W(LEN_W), .MUL_W(MUL_W), .PORT_W(PORT_W)) i_status_frame_gen (
    .clk(clk), .rst_n(rst_n), .hold(hold), .hitless_en(hitless_en), .bank_req(bank_req),
    .cal_len0(cal_len0), .cal_len1(cal_len1), .cal_mul0(cal_mul0), .cal_mul1(cal_mul1),
    .cal_wr_en(cal_wr_en), .cal_wr_bank(cal_wr_bank), .cal_wr_addr(cal_wr_addr),
    .cal_wr_port(cal_wr_port), .stat_port(stat_port), .stat_val(stat_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .act_bank(act_bank), .disabled(disabled)
  );

  typedef struct packed {
    logic             bank;
    logic [LEN_W-1:0] len;
    logic [MUL_W-1:0] mul;
    logic             hen;
  } row_t;

  localparam int NROWS = 5;
  localparam row_t ROWS [NROWS] = '{
    '{1'b0, 10'd3, 8'd2, 1'b0},
    '{1'b1, 10'd4, 8'd1, 1'b1},
    '{1'b0, 10'd1, 8'd3, 1'b1},
    '{1'b1, 10'd5, 8'd2, 1'b0},
    '{1'b0, 10'd2, 8'd1, 1'b1}
  };

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  function automatic logic [7:0] exp_port(input logic b, input int i);
    return b ? 8'(i * 5 + 7) : 8'(i * 3 + 1);
  endfunction

  function automatic logic [1:0] exp_stat(input logic b, input int i);
    logic [7:0] p;
    p = exp_port(b, i);
    return {1'b0, p[0]};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic get_word(output logic [1:0] w, output logic [7:0] p);
    @(negedge clk);
    w = out_data;
    p = stat_port;
    @(posedge clk);
  endtask

  task automatic wait_disabled();
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (disabled) break;
      @(posedge clk);
    end
  endtask

  // Hold the stream, load a configuration, release hold and return the first non-framing word.
  task automatic start_frame(input logic b, input int len, input int mul, input logic hen,
                             output logic [1:0] w, output logic [7:0] p);
    hold = 1'b1;
    wait_disabled();
    if (b) begin cal_len1 = LEN_W'(len); cal_mul1 = MUL_W'(mul); end
    else   begin cal_len0 = LEN_W'(len); cal_mul0 = MUL_W'(mul); end
    bank_req   = b;
    hitless_en = hen;
    hold       = 1'b0;
    w = 2'b11;
    p = '0;
    for (int k = 0; k < 100; k++) begin
      get_word(w, p);
      if (w != 2'b11) break;
    end
  endtask

  task automatic run_row(input row_t r);
    logic [1:0] w;
    logic [7:0] p;
    int errs;
    start_frame(r.bank, int'(r.len), int'(r.mul), r.hen, w, p);
    check("R3 normal frame after hold release", int'(w != 2'b11), 1);
    check("R5 active bank", int'(act_bank), int'(r.bank));
    if (r.hen) begin
      check("R4 select word code", int'(w), r.bank ? 2 : 1);
      get_word(w, p);
    end
    errs = 0;
    for (int rr = 0; rr < int'(r.mul); rr++)
      for (int i = 0; i < int'(r.len); i++) begin
        if (w != exp_stat(r.bank, i) || p != exp_port(r.bank, i)) errs++;
        get_word(w, p);
      end
    check("R6 R7 entry sequence mismatches", errs, 0);
    check("R6 framing word after last repetition", int'(w), 3);
  endtask

  initial begin
    logic [1:0] w, w0;
    logic [7:0] p, p0;
    int errs, cnt;

    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 out_data in reset", int'(out_data), 3);
    check("R1 disabled in reset", int'(disabled), 1);
    check("R1 act_bank in reset", int'(act_bank), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 1);

    // Load calendars of both banks.
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        cal_wr_en   = 1'b1;
        cal_wr_bank = 1'(b);
        cal_wr_addr = LEN_W'(i);
        cal_wr_port = exp_port(1'(b), i);
      end
    @(negedge clk);
    cal_wr_en = 1'b0;

    // Table of configurations walked by one loop.
    for (int k = 0; k < NROWS; k++) run_row(ROWS[k]);

    // R8: zero length then zero repetition count.
    hold = 1'b1;
    wait_disabled();
    cal_len0 = '0; cal_mul0 = 8'd2; bank_req = 1'b0; hitless_en = 1'b0;
    hold = 1'b0;
    cnt = 0;
    for (int k = 0; k < 10; k++) begin
      get_word(w, p);
      if (w == 2'b11 && disabled) cnt++;
    end
    check("R8 zero length gives framing only", cnt, 10);
    @(negedge clk);
    cal_len0 = 10'd3; cal_mul0 = '0;
    repeat (3) @(posedge clk);
    cnt = 0;
    for (int k = 0; k < 10; k++) begin
      get_word(w, p);
      if (w == 2'b11 && disabled) cnt++;
    end
    check("R8 zero repetition gives framing only", cnt, 10);

    // R2: hold raised mid-frame waits for the boundary.
    start_frame(1'b0, 8, 2, 1'b0, w, p);
    get_word(w, p);
    get_word(w, p);
    hold = 1'b1;
    cnt = 0;
    for (int k = 0; k < 13; k++) begin
      get_word(w, p);
      if (w != 2'b11 && !disabled) cnt++;
    end
    check("R2 frame finishes after mid-frame hold", cnt, 13);
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      get_word(w, p);
      if (w == 2'b11) cnt++;
    end
    check("R2 framing only while held", cnt, 8);
    @(negedge clk);
    check("R8 disabled while held", int'(disabled), 1);

    // R5 / R9: mid-frame bank and length change.
    start_frame(1'b0, 6, 1, 1'b1, w, p);
    check("R4 select word bank 0", int'(w), 1);
    bank_req = 1'b1; cal_len0 = 10'd2; cal_len1 = 10'd4; cal_mul1 = 8'd1; hitless_en = 1'b0;
    errs = 0;
    for (int i = 0; i < 6; i++) begin
      get_word(w, p);
      if (p != exp_port(1'b0, i) || act_bank != 1'b0) errs++;
    end
    check("R9 R5 current frame keeps old bank and length", errs, 0);
    get_word(w, p);
    check("R6 framing word closes frame", int'(w), 3);
    get_word(w, p);
    check("R5 new bank adopted at boundary", int'(act_bank), 1);
    check("R4 no select word when disabled", int'(p), int'(exp_port(1'b1, 0)));
    cnt = 1;
    for (int k = 0; k < 6; k++) begin
      get_word(w, p);
      if (w == 2'b11) break;
      cnt++;
    end
    check("R9 new length used in next frame", cnt, 4);

    // R10: back-pressure.
    start_frame(1'b1, 5, 1, 1'b0, w, p);
    @(negedge clk);
    out_ready = 1'b0;
    w0 = out_data;
    p0 = stat_port;
    errs = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (out_data != w0 || stat_port != p0) errs++;
    end
    out_ready = 1'b1;
    @(posedge clk);
    check("R10 outputs stable while stalled", errs, 0);
    check("R10 stalled word is entry 1", int'(p0), int'(exp_port(1'b1, 1)));
    get_word(w, p);
    check("R10 sequence resumes at entry 2", int'(p), int'(exp_port(1'b1, 2)));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule